// File: doc/BRIEF.md
# Master-to-Frame Clock Ratio Detector

This block runs on the master clock of an audio converter. It measures how many master-clock cycles lie between successive rising edges of the frame (left/right) clock. It maps each measured period onto one of seven oversampling ratios: 128, 192, 256, 384, 512, 768 or 1152 master cycles per frame. A ratio is reported only after it has been seen on several consecutive frames. The block also selects the reduced-bandwidth interpolation mode that the two lowest ratios need.

Three conditions are flagged instead of being reported as a lock. The first is a period that fits no ratio. The second is a frame clock that has stopped. The third is a rate that changes again too soon after an earlier change. The frame clock may be asynchronous in phase to the master clock, so it enters through a two-flop synchronizer. Phase jitter within the tolerance window leaves the reported ratio unchanged.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after its release, every output is 0.
- R2: The frame clock passes through two synchronizing flops before edge detection. A period is the number of master cycles between two consecutive detected rising edges. The first rising edge after reset, or after an absence, only starts timing and yields no measurement.
- R3: A period P matches ratio N when N-32 <= P <= N+32. The codes are 0=128, 1=192, 2=256, 3=384, 4=512, 5=768 and 6=1152. Where windows overlap (P=160 and P=224), the lower code wins.
- R4: `locked_o` rises on the 4th consecutive in-window measurement with the same code (parameter `LOCK_FRAMES`). `ratio_code_o` takes that code at the same moment and holds it while locked. A measurement with a different code clears `locked_o` and restarts the run at 1.
- R5: `low_bw_o` is 1 exactly when `locked_o` is 1 and `ratio_code_o` is 0 or 1.
- R6: A measurement outside every window, including any period above 1184, sets `unsupported_o`, clears `locked_o` and resets the run count. The next in-window measurement clears `unsupported_o`.
- R7: If no rising edge is detected for 2048 master cycles (parameter `ABSENT_CYCLES`), `absent_o` is set. One cycle later `locked_o` and `unsupported_o` are cleared and the remembered code is forgotten. The next detected edge clears `absent_o`. An edge detected in the very cycle the timer expires takes precedence, so a period of exactly 2048 is measured (and is unsupported) without raising `absent_o`.
- R8: The block counts measured frames since the last code change, up to `STABLE_FRAMES` (default 1026). If a code change arrives while that count is below `STABLE_FRAMES`, `unstable_o` is set and `locked_o` is held low. `unstable_o` clears at the measurement on which the count reaches `STABLE_FRAMES`. A lock may be granted on that same measurement.
- R9: Periods that alternate around a nominal ratio but stay within ±32 keep the lock and the code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lrclk_i | input | 1 | Frame clock, asynchronous in phase |
| ratio_code_o | output | 3 | Reported ratio code (see R3) |
| locked_o | output | 1 | Ratio qualified and valid |
| low_bw_o | output | 1 | Reduced-bandwidth filter mode select |
| unsupported_o | output | 1 | Last period fit no ratio |
| absent_o | output | 1 | Frame clock stopped |
| unstable_o | output | 1 | Rate changed again too soon |

## Verification
Two events can fall in the same cycle: the frame-edge detection that closes a period, and the expiry of the absence timer. Frames of exactly 2048 cycles make the detected edge land in the cycle where the timer would expire. The bench then judges that a measurement of 2048 (unsupported) is taken and that `absent_o` stays low. Frames of 2049 cycles let the timer win by one cycle, and the bench judges that `absent_o` is raised and that the edge which follows only restarts timing. A behavioural model that tracks every output on every clock judges both cases. The same holds for the cycle in which a code change and the clearing of the stability window meet.

// File: rtl/ratio_det_pkg.sv
package ratio_det_pkg;
  localparam int NUM_RATIOS = 7;
  localparam int CODE_W     = 3;
  typedef logic [CODE_W-1:0] code_t;

  function automatic int nominal_ratio(input int idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      4:       return 512;
      5:       return 768;
      default: return 1152;
    endcase
  endfunction
endpackage

// File: rtl/lr_frame_sync.sv
module lr_frame_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lrclk_i,
  output logic rise_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], lrclk_i};
  end

  // sync_q[1] is the second synchronizer stage
  assign rise_o = sync_q[1] & ~sync_q[2];

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/frame_period_ctr.sv
module frame_period_ctr #(
  parameter int ABSENT_CYCLES = 2048,
  parameter int CNT_W         = $clog2(ABSENT_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic             meas_valid_o,
  output logic [CNT_W-1:0] period_o,
  output logic             timeout_o,
  output logic             absent_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ABSENT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q, absent_q, mv_q, tmo_q;
  logic [CNT_W-1:0] per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      absent_q <= 1'b0;
      mv_q     <= 1'b0;
      tmo_q    <= 1'b0;
      per_q    <= '0;
    end else begin
      mv_q  <= 1'b0;
      tmo_q <= 1'b0;
      if (rise_i) begin
        // edge beats timer expiry in the same cycle
        if (armed_q) begin
          mv_q  <= 1'b1;
          per_q <= cnt_q + 1'b1;
        end
        armed_q  <= 1'b1;
        absent_q <= 1'b0;
        cnt_q    <= '0;
      end else if (cnt_q == LIMIT) begin
        if (!absent_q) begin
          absent_q <= 1'b1;
          tmo_q    <= 1'b1;
          armed_q  <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign meas_valid_o = mv_q;
  assign period_o     = per_q;
  assign timeout_o    = tmo_q;
  assign absent_o     = absent_q;

  AST_ABSENT_NO_MEAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    absent_q |-> !mv_q); // R7
  AST_TMO_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_q |=> !tmo_q); // R7
endmodule

// File: rtl/ratio_classify.sv
module ratio_classify
  import ratio_det_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int TOLERANCE = 32
) (
  input  logic [CNT_W-1:0] period_i,
  output logic             hit_o,
  output code_t            code_o
);
  logic [NUM_RATIOS-1:0] hits;

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
    localparam int NOM = nominal_ratio(g);
    assign hits[g] = (int'(period_i) >= NOM - TOLERANCE) &&
                     (int'(period_i) <= NOM + TOLERANCE);
  end

  // lowest code wins on overlapping windows
  always_comb begin
    hit_o  = |hits;
    code_o = '0;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (hits[i]) code_o = code_t'(i);
    end
  end
endmodule

// File: rtl/ratio_lock_ctl.sv
module ratio_lock_ctl
  import ratio_det_pkg::*;
#(
  parameter int LOCK_FRAMES   = 4,
  parameter int STABLE_FRAMES = 1026,
  parameter int MC_W          = $clog2(LOCK_FRAMES + 1),
  parameter int SC_W          = $clog2(STABLE_FRAMES + 1)
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  meas_valid_i,
  input  logic  hit_i,
  input  code_t code_i,
  input  logic  timeout_i,
  output logic  locked_o,
  output code_t code_o,
  output logic  unsupported_o,
  output logic  unstable_o
);
  localparam logic [MC_W-1:0] LOCK_V = MC_W'(LOCK_FRAMES);
  localparam logic [SC_W-1:0] WIN_V  = SC_W'(STABLE_FRAMES);

  logic            locked_q, locked_n, unsup_q, unsup_n, unst_q, unst_n;
  logic            have_q, have_n;
  code_t           rep_q, rep_n, last_q, last_n;
  logic [MC_W-1:0] mcnt_q, mcnt_n;
  logic [SC_W-1:0] since_q, since_n, since_inc;

  always_comb begin
    locked_n  = locked_q;
    unsup_n   = unsup_q;
    unst_n    = unst_q;
    have_n    = have_q;
    rep_n     = rep_q;
    last_n    = last_q;
    mcnt_n    = mcnt_q;
    since_n   = since_q;
    since_inc = (since_q == WIN_V) ? WIN_V : since_q + 1'b1;
    if (timeout_i) begin
      locked_n = 1'b0;
      unsup_n  = 1'b0;
      mcnt_n   = '0;
      have_n   = 1'b0;
    end else if (meas_valid_i) begin
      since_n = since_inc;
      if (since_inc == WIN_V) unst_n = 1'b0;
      if (!hit_i) begin
        unsup_n  = 1'b1;
        locked_n = 1'b0;
        mcnt_n   = '0;
      end else begin
        unsup_n = 1'b0;
        have_n  = 1'b1;
        last_n  = code_i;
        if (have_q && code_i != last_q) begin
          since_n = '0;
          mcnt_n  = MC_W'(1);
          if (since_q < WIN_V) unst_n = 1'b1;
        end else begin
          mcnt_n = (mcnt_q == LOCK_V) ? LOCK_V : mcnt_q + 1'b1;
        end
        locked_n = (mcnt_n == LOCK_V) && !unst_n;
        if (locked_n) rep_n = code_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      unsup_q  <= 1'b0;
      unst_q   <= 1'b0;
      have_q   <= 1'b0;
      rep_q    <= '0;
      last_q   <= '0;
      mcnt_q   <= '0;
      since_q  <= WIN_V;
    end else begin
      locked_q <= locked_n;
      unsup_q  <= unsup_n;
      unst_q   <= unst_n;
      have_q   <= have_n;
      rep_q    <= rep_n;
      last_q   <= last_n;
      mcnt_q   <= mcnt_n;
      since_q  <= since_n;
    end
  end

  assign locked_o      = locked_q;
  assign code_o        = rep_q;
  assign unsupported_o = unsup_q;
  assign unstable_o    = unst_q;

  AST_LOCK_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> mcnt_q == LOCK_V); // R4
  AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q && $past(locked_q) |-> $stable(rep_q)); // R4
  AST_UNSTABLE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unst_q |-> !locked_q); // R8
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
  import ratio_det_pkg::*;
#(
  parameter int ABSENT_CYCLES = 2048,
  parameter int LOCK_FRAMES   = 4,
  parameter int STABLE_FRAMES = 1026,
  parameter int TOLERANCE     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lrclk_i,
  output logic [CODE_W-1:0] ratio_code_o,
  output logic              locked_o,
  output logic              low_bw_o,
  output logic              unsupported_o,
  output logic              absent_o,
  output logic              unstable_o
);
  localparam int CNT_W = $clog2(ABSENT_CYCLES + 1);

  logic             rise, meas_valid, timeout, hit;
  logic [CNT_W-1:0] period;
  code_t            hit_code, rep_code;

  lr_frame_sync u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lrclk_i (lrclk_i),
    .rise_o  (rise)
  );

  frame_period_ctr #(
    .ABSENT_CYCLES (ABSENT_CYCLES),
    .CNT_W         (CNT_W)
  ) u_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rise_i       (rise),
    .meas_valid_o (meas_valid),
    .period_o     (period),
    .timeout_o    (timeout),
    .absent_o     (absent_o)
  );

  ratio_classify #(
    .CNT_W     (CNT_W),
    .TOLERANCE (TOLERANCE)
  ) u_cls (
    .period_i (period),
    .hit_o    (hit),
    .code_o   (hit_code)
  );

  ratio_lock_ctl #(
    .LOCK_FRAMES   (LOCK_FRAMES),
    .STABLE_FRAMES (STABLE_FRAMES)
  ) u_lock (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .meas_valid_i  (meas_valid),
    .hit_i         (hit),
    .code_i        (hit_code),
    .timeout_i     (timeout),
    .locked_o      (locked_o),
    .code_o        (rep_code),
    .unsupported_o (unsupported_o),
    .unstable_o    (unstable_o)
  );

  assign ratio_code_o = rep_code;
  assign low_bw_o     = locked_o && (rep_code <= code_t'(1));

  AST_UNSUP_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsupported_o |-> !locked_o); // R6
  AST_ABSENT_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    absent_o && $past(absent_o) |-> !locked_o); // R7
endmodule

// File: tb/tb_mclk_ratio_detect.sv
`timescale 1ns/1ps
module tb_mclk_ratio_detect;
  localparam int ABS  = 2048;
  localparam int LOCK = 4;
  localparam int WIN  = 8;
  localparam int TOL  = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lrclk = 1'b0;
  logic [2:0] code;
  logic       locked, low_bw, unsup, absent, unst;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  mclk_ratio_detect #(
    .ABSENT_CYCLES (ABS),
    .LOCK_FRAMES   (LOCK),
    .STABLE_FRAMES (WIN),
    .TOLERANCE     (TOL)
  ) dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .lrclk_i       (lrclk),
    .ratio_code_o  (code),
    .locked_o      (locked),
    .low_bw_o      (low_bw),
    .unsupported_o (unsup),
    .absent_o      (absent),
    .unstable_o    (unst)
  );

  // behavioural reference model
  int noms[7] = '{128, 192, 256, 384, 512, 768, 1152};
  int m_s1, m_s2, m_s3, m_cnt, m_armed, m_absent, m_ev, m_per, m_tmo;
  int m_locked, m_rep, m_unsup, m_unst, m_have, m_last, m_mcnt, m_since;

  function automatic int classify(input int p);
    for (int i = 0; i < 7; i++)
      if (p >= noms[i] - TOL && p <= noms[i] + TOL) return i;
    return -1;
  endfunction

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_armed = 0; m_absent = 0;
    m_ev = 0; m_per = 0; m_tmo = 0; m_locked = 0; m_rep = 0; m_unsup = 0;
    m_unst = 0; m_have = 0; m_last = 0; m_mcnt = 0; m_since = WIN;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int c, si, chg, rise, ev_n, tmo_n, per_n;
      if (m_tmo != 0) begin
        m_locked = 0; m_unsup = 0; m_mcnt = 0; m_have = 0;
      end else if (m_ev != 0) begin
        c  = classify(m_per);
        si = (m_since >= WIN) ? WIN : m_since + 1;
        if (si == WIN) m_unst = 0;
        if (c < 0) begin
          m_since = si; m_unsup = 1; m_locked = 0; m_mcnt = 0;
        end else begin
          m_unsup = 0;
          chg = (m_have != 0 && c != m_last);
          if (chg) begin
            if (m_since < WIN) m_unst = 1;
            m_since = 0; m_mcnt = 1;
          end else begin
            m_since = si;
            m_mcnt = (m_mcnt >= LOCK) ? LOCK : m_mcnt + 1;
          end
          m_have = 1; m_last = c;
          m_locked = (m_mcnt == LOCK && m_unst == 0);
          if (m_locked != 0) m_rep = c;
        end
      end
      rise = (m_s2 != 0 && m_s3 == 0);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = lrclk;
      ev_n = 0; tmo_n = 0; per_n = m_per;
      if (rise) begin
        if (m_armed != 0) begin ev_n = 1; per_n = m_cnt + 1; end
        m_armed = 1; m_absent = 0; m_cnt = 0;
      end else if (m_cnt == ABS - 1) begin
        if (m_absent == 0) begin m_absent = 1; tmo_n = 1; m_armed = 0; end
      end else m_cnt = m_cnt + 1;
      m_ev = ev_n; m_tmo = tmo_n; m_per = per_n;
    end
  end

  int exp_lbw;
  always @(negedge clk) begin
    if (rst_n) begin
      int bad;
      bad = 0;
      exp_lbw = (m_locked != 0 && m_rep <= 1);
      compared++;
      if (int'(code) != m_rep) begin bad = 1;
        $display("FAIL R4 ratio_code act=%0d exp=%0d t=%0t", code, m_rep, $time); end
      if (int'(locked) != m_locked) begin bad = 1;
        $display("FAIL R4 locked act=%0d exp=%0d t=%0t", locked, m_locked, $time); end
      if (int'(low_bw) != exp_lbw) begin bad = 1;
        $display("FAIL R5 low_bw act=%0d exp=%0d t=%0t", low_bw, exp_lbw, $time); end
      if (int'(unsup) != m_unsup) begin bad = 1;
        $display("FAIL R6 unsupported act=%0d exp=%0d t=%0t", unsup, m_unsup, $time); end
      if (int'(absent) != m_absent) begin bad = 1;
        $display("FAIL R7 absent act=%0d exp=%0d t=%0t", absent, m_absent, $time); end
      if (int'(unst) != m_unst) begin bad = 1;
        $display("FAIL R8 unstable act=%0d exp=%0d t=%0t", unst, m_unst, $time); end
      if (bad != 0) mismatched++;
    end
  end

  task automatic dcheck(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic frames(input int p, input int n, input int jit);
    for (int k = 0; k < n; k++) begin
      int per;
      per = p + (((k % 2) == 0) ? jit : -jit);
      lrclk = 1'b1;
      repeat (per / 2) @(negedge clk);
      lrclk = 1'b0;
      repeat (per - per / 2) @(negedge clk);
    end
  endtask

  task automatic expect_lock(input string tag, input int c);
    dcheck({tag, " locked"}, int'(locked), 1);
    dcheck({tag, " code"}, int'(code), c);
    dcheck("R5 low_bw", int'(low_bw), (c <= 1) ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    dcheck("R1 locked in reset", int'(locked), 0);
    dcheck("R1 outputs in reset", int'({code, low_bw, unsup, absent, unst}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    dcheck("R1 outputs after release", int'({code, locked, low_bw, unsup, absent, unst}), 0);
    // R2: first edge only starts timing, so 4 frames give 3 measurements
    frames(256, 4, 0);
    dcheck("R2 no lock after 3 measurements", int'(locked), 0);
    frames(256, 6, 0);
    expect_lock("R4 256", 2);
    frames(128, 10, 0);   expect_lock("R3 128", 0);
    frames(1152, 10, 0);  expect_lock("R3 1152", 6);
    frames(384, 10, 20);  expect_lock("R9 384 jitter", 3);
    frames(768, 10, 30);  expect_lock("R9 768 jitter", 5);
    frames(512, 10, 0);   expect_lock("R3 512", 4);
    frames(192, 10, 0);   expect_lock("R3 192", 1);
    frames(160, 10, 0);   expect_lock("R3 overlap 160", 0);
    frames(224, 10, 0);   expect_lock("R3 overlap 224", 1);
    frames(96, 10, 0);    expect_lock("R3 low edge 96", 0);
    frames(1184, 10, 0);  expect_lock("R3 high edge 1184", 6);
    frames(300, 3, 0);
    dcheck("R6 unsupported 300", int'(unsup), 1);
    dcheck("R6 unlocked 300", int'(locked), 0);
    frames(1185, 3, 0);
    dcheck("R6 unsupported 1185", int'(unsup), 1);
    frames(256, 10, 0);
    dcheck("R6 unsupported cleared", int'(unsup), 0);
    expect_lock("R6 relock", 2);
    // R8: quick change back
    frames(512, 10, 0);
    frames(256, 3, 0);
    frames(512, 3, 0);
    dcheck("R8 unstable set", int'(unst), 1);
    dcheck("R8 lock withheld", int'(locked), 0);
    frames(512, 9, 0);
    dcheck("R8 unstable cleared", int'(unst), 0);
    expect_lock("R8 relock", 4);
    // R7: frame clock stops
    lrclk = 1'b0;
    repeat (2100) @(negedge clk);
    dcheck("R7 absent set", int'(absent), 1);
    dcheck("R7 unlocked", int'(locked), 0);
    frames(256, 10, 0);
    dcheck("R7 absent cleared", int'(absent), 0);
    expect_lock("R7 relock", 2);
    // R7 corner: edge in the expiry cycle wins
    frames(2048, 3, 0);
    dcheck("R7 2048 not absent", int'(absent), 0);
    dcheck("R7 2048 unsupported", int'(unsup), 1);
    frames(2049, 2, 0);
    frames(256, 10, 0);
    expect_lock("R7 after 2049", 2);
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule